// File: doc/BRIEF.md
# One-Time-Programmable Fuse Burn Sequencer

This controller burns a chosen set of configuration bits into a one-time-programmable fuse array, one bit at a time. A start pulse samples a bit mask. The sequencer then clears every shadow latch and raises a read-inhibit line. Only after that does it switch on the external high-voltage programming supply. For each masked bit, taken in ascending address order, it waits for the supply-stable comparator. It then sets that bit's shadow latch, drives the write enable for a programming pulse of at least 300 µs, drops the write enable and clears the same latch. After the last bit it switches the supply off. It holds read-inhibit until the below-3 V comparator reports that the supply has decayed, and only then releases it.

Once read-inhibit is released, the sequencer asks an external verifier for a result. A failed verify restarts the whole job from the latch clear, using the same mask, up to a parameterised number of retries; after that it reports an error. One bit index is the lock bit. When it is part of the job, the chip-select line stays active without a break from the first latch set until the supply has decayed, because a gap would cut the burn short and could harm the part. When the supply never becomes stable within a timeout, the sequencer ramps down, waits for the decay, releases read-inhibit and flags an error without setting any latch.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset, every output is low and `latch_addr` is 0.
- R2: A start pulse while idle with a non-zero mask gives one cycle of `latch_clr_all`, then one cycle of `read_inhibit` alone, then `hv_en` together with `read_inhibit`; `hv_en` is never high without `read_inhibit`.
- R3: For each bit the order is: one cycle of `latch_set` with its address, `write_en` high for exactly HOLD_CYC = ceil(CLK_FREQ_HZ × HOLD_US / 10^6) cycles, one cycle with all strobes low, then one cycle of `latch_clr` with the same address.
- R4: Within one attempt, every mask bit is burned exactly once, in ascending address order (bit i of `burn_mask` is address i).
- R5: A shadow latch is never set while a previously set one has not been cleared.
- R6: Each `latch_set` follows a clock edge at which `vpp_stable` was sampled high; the sequencer waits for stability again before every bit, and `write_en` is high only while `hv_en` is high.
- R7: After the last latch clear, `hv_en` drops for one cycle while `read_inhibit` stays high. `read_inhibit` stays high until `vpp_low` is sampled high, and falls in the following cycle.
- R8: After release, `verify_req` stays high until `verify_done`. With `verify_ok` high the job ends with `done`. With it low the job restarts at the latch clear with the same mask; after MAX_RETRY restarts a further failure ends with `error`.
- R9: When bit LOCK_IDX is in the mask, `chip_sel` rises at the first `latch_set` and stays high until `vpp_low` ends the decay wait. Without it, `chip_sel` is high only from each `latch_set` to its `latch_clr`.
- R10: If `vpp_stable` is not seen within TMO_CYC cycles of a stability wait, no further latch is set. The supply is turned off, the decay is awaited, `read_inhibit` is released and the job ends with `error`.
- R11: A start with an all-zero mask sets `done` in the next cycle without leaving idle. A start while busy is ignored.
- R12: While idle, `hv_en`, `write_en`, `read_inhibit`, `chip_sel` and the latch strobes are low. `done` and `error` hold their value until the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, sampled while idle |
| burn_mask | input | NBITS | Bits to burn, bit i is address i |
| vpp_stable | input | 1 | Programming supply has settled |
| vpp_low | input | 1 | Programming supply is below 3 V |
| verify_done | input | 1 | Verifier has a result |
| verify_ok | input | 1 | Verifier result, valid with verify_done |
| latch_clr_all | output | 1 | Clear every shadow latch |
| latch_set | output | 1 | Set the shadow latch at latch_addr |
| latch_clr | output | 1 | Clear the shadow latch at latch_addr |
| latch_addr | output | clog2(NBITS) | Bit address of the latch strobes, 0 outside a bit burn |
| read_inhibit | output | 1 | Read-disable line for the fuse array |
| write_en | output | 1 | Fuse write enable |
| hv_en | output | 1 | Enable for the external programming supply |
| chip_sel | output | 1 | Chip-select line, active high |
| verify_req | output | 1 | Request for a verification result |
| busy | output | 1 | A job is in progress |
| done | output | 1 | Last job completed and verified |
| error | output | 1 | Last job ended in timeout or retry exhaustion |

## Verification
The in-RTL assertions check the local ordering rules on every cycle. They cover read-inhibit around the supply enable, the exact write-enable width, the pairing of set and clear addresses, the single-latch rule, ascending order, the stability precondition, release only after decay, and the unbroken chip-select while the lock bit is being burned. Other behaviours only show up in the bench's scenarios. These are the whole-job outcome after one or more verify failures, the retry count before an error, the timeout path with a supply that never settles, the empty-mask shortcut, and a start ignored during a job. The bench's cycle model compares every output on every cycle against the sequence the requirements dictate.

// File: rtl/otp_prog_pkg.sv
// Package: shared types of the fuse burn sequencer.
// Assumes nothing beyond IEEE 1800-2017; holds the sequencer state encoding.
package otp_prog_pkg;

    // Sequencer phases, in the order a normal job walks them.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_INHIBIT,
        ST_WAIT_UP,
        ST_SET,
        ST_HOLD,
        ST_RELEASE_WE,
        ST_UNSET,
        ST_SUPPLY_OFF,
        ST_WAIT_DOWN,
        ST_UNINHIBIT,
        ST_VERIFY
    } seq_state_e;

endpackage

// File: rtl/otp_low_bit_scan.sv
// Module: lowest-set-bit finder.
// Returns the index of the lowest set bit of vec, or 0 when vec is empty.
// Assumes the caller checks emptiness separately; purely combinational.
module otp_low_bit_scan #(
    parameter int N  = 16,
    parameter int AW = 4
) (
    input  logic [N-1:0]  vec,
    output logic [AW-1:0] idx
);

    // Scan from the top so the lowest set bit is the last one to write idx.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = AW'(i);
        end
    end

endmodule

// File: rtl/otp_cycle_timer.sv
// Module: run-length timer.
// Counts cycles while run is high and restarts from zero whenever run drops.
// expired is high in the LIMIT-th consecutive cycle of run.
// Assumes LIMIT >= 1 and that run goes low for at least one cycle between uses.
module otp_cycle_timer #(
    parameter int LIMIT = 300,
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt_q;

    // Cycle counter: cleared while idle, saturates at LIMIT-1 while running.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (!run)                     cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT - 1))  cnt_q <= cnt_q + 1'b1;
    end

    // Expiry flag for the current cycle.
    assign expired = run && (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/otp_burn_seq.sv
// Module: one-time-programmable fuse burn sequencer (top).
// Samples a bit mask on start and burns the masked bits one at a time in
// ascending order under the supply, read-inhibit and write-enable ordering.
// It verifies the result, retries a failed verify, and times out on a supply
// that never settles.
// Assumes: vpp_stable / vpp_low come from synchronised comparators.
// verify_done is a pulse answering verify_req.
// CLK_FREQ_HZ is the real clock rate, so the write pulse is never shorter than HOLD_US.
module otp_burn_seq
    import otp_prog_pkg::*;
#(
    parameter int NBITS       = 16,
    parameter int LOCK_IDX    = 15,
    parameter int CLK_FREQ_HZ = 1_000_000,
    parameter int HOLD_US     = 300,
    parameter int TMO_CYC     = 1000,
    parameter int MAX_RETRY   = 2,
    localparam int AW = (NBITS > 1) ? $clog2(NBITS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NBITS-1:0] burn_mask,
    input  logic             vpp_stable,
    input  logic             vpp_low,
    input  logic             verify_done,
    input  logic             verify_ok,
    output logic             latch_clr_all,
    output logic             latch_set,
    output logic             latch_clr,
    output logic [AW-1:0]    latch_addr,
    output logic             read_inhibit,
    output logic             write_en,
    output logic             hv_en,
    output logic             chip_sel,
    output logic             verify_req,
    output logic             busy,
    output logic             done,
    output logic             error
);

    localparam longint HOLD_PROD = longint'(CLK_FREQ_HZ) * longint'(HOLD_US);
    localparam int     HOLD_RAW  = int'((HOLD_PROD + 64'd999_999) / 64'd1_000_000);
    localparam int     HOLD_CYC  = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
    localparam int     RW        = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;

    seq_state_e       st_q, st_d;
    logic [NBITS-1:0] mask_q, pend_q, pend_next;
    logic [AW-1:0]    cur_idx;
    logic [RW-1:0]    retry_q;
    logic             abort_q, burned_q, done_q, err_q;
    logic             hold_hit, tmo_hit, last_bit, lock_q, in_bit;

    // Next bit to burn: the lowest still pending.
    otp_low_bit_scan #(.N(NBITS), .AW(AW)) u_scan (
        .vec (pend_q),
        .idx (cur_idx)
    );

    // Write pulse width timer.
    otp_cycle_timer #(.LIMIT(HOLD_CYC)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_HOLD),
        .expired (hold_hit)
    );

    // Supply stability timeout timer.
    otp_cycle_timer #(.LIMIT(TMO_CYC)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_WAIT_UP),
        .expired (tmo_hit)
    );

    // Pending set after the current bit is cleared, and whether it was the last.
    assign pend_next = pend_q & ~(NBITS'(1) << cur_idx);
    assign last_bit  = (pend_next == '0);
    assign lock_q    = mask_q[LOCK_IDX];

    // Phase transitions.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:       if (start && (burn_mask != '0)) st_d = ST_CLEAR;
            ST_CLEAR:      st_d = ST_INHIBIT;
            ST_INHIBIT:    st_d = ST_WAIT_UP;
            ST_WAIT_UP: begin
                if (vpp_stable)   st_d = ST_SET;
                else if (tmo_hit) st_d = ST_SUPPLY_OFF;
            end
            ST_SET:        st_d = ST_HOLD;
            ST_HOLD:       if (hold_hit) st_d = ST_RELEASE_WE;
            ST_RELEASE_WE: st_d = ST_UNSET;
            ST_UNSET:      st_d = last_bit ? ST_SUPPLY_OFF : ST_WAIT_UP;
            ST_SUPPLY_OFF: st_d = ST_WAIT_DOWN;
            ST_WAIT_DOWN:  if (vpp_low) st_d = ST_UNINHIBIT;
            ST_UNINHIBIT:  st_d = abort_q ? ST_IDLE : ST_VERIFY;
            ST_VERIFY: begin
                if (verify_done) begin
                    if (verify_ok || (retry_q == RW'(MAX_RETRY))) st_d = ST_IDLE;
                    else                                        st_d = ST_CLEAR;
                end
            end
            default:       st_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Job mask capture and pending-bit bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
        end else if (st_q == ST_IDLE && start) begin
            mask_q <= burn_mask;
            pend_q <= burn_mask;
        end else if (st_q == ST_UNSET) begin
            pend_q <= pend_next;
        end else if (st_q == ST_VERIFY && verify_done && !verify_ok) begin
            pend_q <= mask_q;
        end
    end

    // Retry count for failed verifies.
    always_ff @(posedge clk) begin
        if (!rst_n)
            retry_q <= '0;
        else if (st_q == ST_IDLE && start)
            retry_q <= '0;
        else if (st_q == ST_VERIFY && verify_done && !verify_ok && retry_q != RW'(MAX_RETRY))
            retry_q <= retry_q + 1'b1;
    end

    // Timeout abort flag for the current job.
    always_ff @(posedge clk) begin
        if (!rst_n)                                         abort_q <= 1'b0;
        else if (st_q == ST_IDLE && start)                  abort_q <= 1'b0;
        else if (st_q == ST_WAIT_UP && !vpp_stable && tmo_hit) abort_q <= 1'b1;
    end

    // Marks that the current attempt has set its first latch.
    always_ff @(posedge clk) begin
        if (!rst_n)                 burned_q <= 1'b0;
        else if (st_q == ST_CLEAR)  burned_q <= 1'b0;
        else if (st_q == ST_SET)    burned_q <= 1'b1;
    end

    // Sticky done and error status, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (st_q == ST_IDLE && start) begin
            done_q <= (burn_mask == '0);
            err_q  <= 1'b0;
        end else if (st_q == ST_UNINHIBIT && abort_q) begin
            err_q <= 1'b1;
        end else if (st_q == ST_VERIFY && verify_done) begin
            if (verify_ok)                        done_q <= 1'b1;
            else if (retry_q == RW'(MAX_RETRY))   err_q  <= 1'b1;
        end
    end

    // Output decode from the phase.
    assign in_bit        = st_q inside {ST_SET, ST_HOLD, ST_RELEASE_WE, ST_UNSET};
    assign latch_clr_all = (st_q == ST_CLEAR);
    assign latch_set     = (st_q == ST_SET);
    assign latch_clr     = (st_q == ST_UNSET);
    assign latch_addr    = in_bit ? cur_idx : '0;
    assign write_en      = (st_q == ST_HOLD);
    assign hv_en         = (st_q == ST_WAIT_UP) || in_bit;
    assign read_inhibit  = st_q inside {ST_INHIBIT, ST_WAIT_UP, ST_SET, ST_HOLD,
                                        ST_RELEASE_WE, ST_UNSET, ST_SUPPLY_OFF, ST_WAIT_DOWN};
    assign chip_sel      = in_bit || (lock_q && burned_q &&
                           (st_q inside {ST_WAIT_UP, ST_SUPPLY_OFF, ST_WAIT_DOWN}));
    assign verify_req    = (st_q == ST_VERIFY);
    assign busy          = (st_q != ST_IDLE);
    assign done          = done_q;
    assign error         = err_q;

    // ---------------------------------------------------------------
    // Assertions and their observation registers
    // ---------------------------------------------------------------
    logic          latch_held_q, seen_q;
    logic [AW-1:0] set_addr_q, last_addr_q;
    logic [31:0]   we_len_q;

    // Observation of latch occupancy, order and write pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_held_q <= 1'b0;
            seen_q       <= 1'b0;
            set_addr_q   <= '0;
            last_addr_q  <= '0;
            we_len_q     <= '0;
        end else begin
            if (latch_set) begin
                latch_held_q <= 1'b1;
                set_addr_q   <= latch_addr;
                last_addr_q  <= latch_addr;
                seen_q       <= 1'b1;
            end else if (latch_clr || latch_clr_all) begin
                latch_held_q <= 1'b0;
            end
            if (latch_clr_all) seen_q <= 1'b0;
            we_len_q <= write_en ? we_len_q + 1 : '0;
        end
    end

    assert_idle_safe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!hv_en && !write_en && !read_inhibit && !chip_sel && !latch_set && !latch_clr));

    assert_rd_covers_hv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> read_inhibit);

    assert_rd_before_hv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> $past(read_inhibit));

    assert_we_after_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(write_en) |-> $past(latch_set));

    assert_we_not_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
        write_en |-> (we_len_q < 32'(HOLD_CYC)));

    assert_we_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(write_en) |-> ($past(we_len_q) == 32'(HOLD_CYC - 1)));

    assert_clr_same_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_clr |-> (latch_addr == set_addr_q));

    assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_set && seen_q) |-> (latch_addr > last_addr_q));

    assert_single_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_set |-> !latch_held_q);

    assert_stable_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        latch_set |-> $past(vpp_stable));

    assert_we_needs_hv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        write_en |-> (hv_en && chip_sel));

    assert_rd_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(read_inhibit) |-> ($past(vpp_low) && !$past(hv_en)));

    assert_verify_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        verify_req |-> (!read_inhibit && !hv_en));

    assert_cs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(chip_sel) && lock_q) |-> ($past(vpp_low) && !$past(hv_en)));

endmodule

// File: tb/otp_burn_seq_test.sv
`timescale 1ns/1ps
// Bench: behavioural cycle model of the burn sequencer compared on every clock,
// plus scenario checks on whole-job outcomes.
module otp_burn_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int NB        = 16;
    localparam int AWB       = 4;
    localparam int LOCKB     = 15;
    localparam int CLK_HZ    = 1_000_000;
    localparam int TMO       = 1000;
    localparam int MAXR      = 2;
    localparam int EXP_HOLD  = (CLK_HZ / 1000) * 300 / 1000;
    localparam int OW        = 11 + AWB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NB-1:0] burn_mask = '0;
    logic vpp_stable = 1'b0;
    logic vpp_low = 1'b1;
    logic verify_done = 1'b0;
    logic verify_ok = 1'b0;
    logic latch_clr_all, latch_set, latch_clr, read_inhibit, write_en, hv_en;
    logic chip_sel, verify_req, busy, done, error;
    logic [AWB-1:0] latch_addr;

    otp_burn_seq #(
        .NBITS(NB), .LOCK_IDX(LOCKB), .CLK_FREQ_HZ(CLK_HZ), .HOLD_US(300),
        .TMO_CYC(TMO), .MAX_RETRY(MAXR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .burn_mask(burn_mask),
        .vpp_stable(vpp_stable), .vpp_low(vpp_low), .verify_done(verify_done),
        .verify_ok(verify_ok), .latch_clr_all(latch_clr_all), .latch_set(latch_set),
        .latch_clr(latch_clr), .latch_addr(latch_addr), .read_inhibit(read_inhibit),
        .write_en(write_en), .hv_en(hv_en), .chip_sel(chip_sel), .verify_req(verify_req),
        .busy(busy), .done(done), .error(error)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Scenario knobs and records
    int stb_dly = 3;
    int low_dly = 4;
    bit vq[$];
    int set_log[$];
    int n_clrall = 0;
    int n_csfall = 0;
    int we_run = 0;
    bit saw_busy = 1'b0;
    bit model_on = 1'b0;

    // Expected outputs from the model
    bit e_ca, e_ls, e_lc, e_ri, e_we, e_hv, e_cs, e_vr, e_busy, e_done, e_err;
    int e_addr;
    string e_tag = "R1";
    bit m_done = 1'b0, m_err = 1'b0;
    bit s_start, s_stable, s_low, s_vdone, s_vok;
    logic [NB-1:0] s_mask;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // ---- reference model ----
    task automatic tick();
        @(posedge clk);
        s_start = start; s_mask = burn_mask; s_stable = vpp_stable;
        s_low = vpp_low; s_vdone = verify_done; s_vok = verify_ok;
        #1;
    endtask

    task automatic setx(input bit ca, ls, lc, input int addr, input bit ri, we, hv, cs, vr,
                        input string tag);
        e_ca = ca; e_ls = ls; e_lc = lc; e_addr = addr; e_ri = ri; e_we = we;
        e_hv = hv; e_cs = cs; e_vr = vr; e_busy = 1'b1; e_done = m_done; e_err = m_err;
        e_tag = tag;
    endtask

    task automatic set_idle();
        e_ca = 0; e_ls = 0; e_lc = 0; e_addr = 0; e_ri = 0; e_we = 0; e_hv = 0;
        e_cs = 0; e_vr = 0; e_busy = 0; e_done = m_done; e_err = m_err; e_tag = "R12";
    endtask

    task automatic run_job(input logic [NB-1:0] mask);
        bit lock, aborted, started;
        int k;
        lock = mask[LOCKB];
        for (int att = 0; att <= MAXR; att++) begin
            aborted = 0; started = 0;
            setx(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2"); tick();
            setx(0, 0, 0, 0, 1, 0, 0, 0, 0, "R2"); tick();
            for (int b = 0; b < NB; b++) begin
                if (mask[b] && !aborted) begin
                    setx(0, 0, 0, 0, 1, 0, 1, lock && started, 0, "R6");
                    k = 0;
                    forever begin
                        tick();
                        if (s_stable) break;
                        if (k == TMO - 1) begin aborted = 1; break; end
                        k++;
                    end
                    if (!aborted) begin
                        started = 1;
                        setx(0, 1, 0, b, 1, 0, 1, 1, 0, "R5"); tick();
                        repeat (EXP_HOLD) begin
                            setx(0, 0, 0, b, 1, 1, 1, 1, 0, "R3"); tick();
                        end
                        setx(0, 0, 0, b, 1, 0, 1, 1, 0, "R3"); tick();
                        setx(0, 0, 1, b, 1, 0, 1, 1, 0, "R5"); tick();
                    end
                end
            end
            setx(0, 0, 0, 0, 1, 0, 0, lock && started, 0, aborted ? "R10" : "R7"); tick();
            setx(0, 0, 0, 0, 1, 0, 0, lock && started, 0, aborted ? "R10" : "R7");
            forever begin tick(); if (s_low) break; end
            setx(0, 0, 0, 0, 0, 0, 0, 0, 0, "R7"); tick();
            if (aborted) begin m_err = 1; return; end
            setx(0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
            forever begin tick(); if (s_vdone) break; end
            if (s_vok) begin m_done = 1; return; end
            if (att == MAXR) begin m_err = 1; return; end
        end
    endtask

    initial begin : ref_model
        set_idle();
        wait (rst_n);
        model_on = 1'b1;
        forever begin
            set_idle();
            tick();
            if (s_start) begin
                if (s_mask == '0) begin m_done = 1; m_err = 0; end
                else begin m_done = 0; m_err = 0; run_job(s_mask); end
            end
        end
    end

    // ---- every-cycle comparison and monitors ----
    initial begin : compare_mon
        logic [OW-1:0] act, exp;
        bit cs_prev;
        cs_prev = 0;
        forever begin
            @(negedge clk);
            if (rst_n && model_on) begin
                act = {latch_clr_all, latch_set, latch_clr, latch_addr, read_inhibit,
                       write_en, hv_en, chip_sel, verify_req, busy, done, error};
                exp = {e_ca, e_ls, e_lc, AWB'(e_addr), e_ri, e_we, e_hv, e_cs, e_vr,
                       e_busy, e_done, e_err};
                n_checks++;
                if (act !== exp) begin
                    n_fail++;
                    $display("FAIL %s cycle compare at %0t: actual %h expected %h",
                             e_tag, $time, act, exp);
                end
                if (latch_set) set_log.push_back(int'(latch_addr));
                if (latch_clr_all) n_clrall++;
                if (cs_prev && !chip_sel) n_csfall++;
                if (busy) saw_busy = 1'b1;
                if (write_en) we_run++;
                else if (we_run > 0) begin
                    chk("R3", "write pulse cycles", we_run, EXP_HOLD);
                    we_run = 0;
                end
            end
            cs_prev = chip_sel;
        end
    end

    // ---- supply model: settles stb_dly cycles after enable, decays low_dly after off ----
    initial begin : supply_model
        int on_cnt, off_cnt;
        on_cnt = 0; off_cnt = 100;
        forever begin
            @(negedge clk);
            if (hv_en) begin
                off_cnt = 0; vpp_low = 1'b0;
                if (stb_dly >= 0 && on_cnt >= stb_dly) vpp_stable = 1'b1;
                on_cnt++;
            end else begin
                on_cnt = 0; vpp_stable = 1'b0;
                if (off_cnt >= low_dly) vpp_low = 1'b1;
                off_cnt++;
            end
        end
    end

    // ---- verifier model: answers three cycles after the request ----
    initial begin : verifier_model
        int wait_cnt;
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (verify_done) begin
                verify_done = 1'b0; verify_ok = 1'b0; wait_cnt = 0;
            end else if (verify_req) begin
                wait_cnt++;
                if (wait_cnt == 3) begin
                    verify_done = 1'b1;
                    verify_ok = (vq.size() > 0) ? vq.pop_front() : 1'b1;
                end
            end
        end
    end

    // ---- watchdog ----
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
        end
    end

    task automatic clear_logs();
        set_log.delete(); n_clrall = 0; n_csfall = 0; saw_busy = 1'b0;
    endtask

    task automatic pulse_start(input logic [NB-1:0] m);
        @(negedge clk);
        start = 1'b1; burn_mask = m;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_and_wait(input logic [NB-1:0] m);
        clear_logs();
        pulse_start(m);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : stimulus
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "outputs under reset", int'({latch_clr_all, latch_set, latch_clr, read_inhibit,
            write_en, hv_en, chip_sel, verify_req, busy, done, error}), 0);
        chk("R1", "latch_addr under reset", int'(latch_addr), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Two plain bits, with a start issued mid-job (R4, R9, R11)
        clear_logs();
        pulse_start(16'h0012);
        repeat (40) @(negedge clk);
        pulse_start(16'h0001);
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R4", "bits burned", set_log.size(), 2);
        if (set_log.size() == 2) begin
            chk("R4", "first address", set_log[0], 1);
            chk("R4", "second address", set_log[1], 4);
        end
        chk("R11", "mid-job start ignored, clear-all count", n_clrall, 1);
        chk("R9", "chip_sel drops per bit without lock", n_csfall, 2);
        chk("R8", "done after good verify", int'(done), 1);
        chk("R12", "error clear", int'(error), 0);

        // Lock bit in the list (R9)
        run_and_wait(16'h8001);
        chk("R9", "chip_sel held through lock burn", n_csfall, 1);
        chk("R4", "bits burned with lock", set_log.size(), 2);
        if (set_log.size() == 2) chk("R4", "lock bit last", set_log[1], 15);
        chk("R8", "done with lock", int'(done), 1);

        // One failed verify then success (R8)
        vq = '{1'b0, 1'b1};
        run_and_wait(16'h0008);
        chk("R8", "restart count after one failure", n_clrall, 2);
        chk("R4", "bit burned once per attempt", set_log.size(), 2);
        chk("R8", "done after retry", int'(done), 1);

        // Verify always fails (R8)
        vq = '{1'b0, 1'b0, 1'b0};
        run_and_wait(16'h0040);
        chk("R8", "attempts before error", n_clrall, MAXR + 1);
        chk("R8", "error after retries", int'(error), 1);
        chk("R12", "done stays low on error", int'(done), 0);

        // Supply never settles (R10)
        stb_dly = -1;
        run_and_wait(16'h0004);
        chk("R10", "no latch set on timeout", set_log.size(), 0);
        chk("R10", "error on timeout", int'(error), 1);
        chk("R12", "supply off after timeout", int'(hv_en), 0);
        chk("R12", "read_inhibit off after timeout", int'(read_inhibit), 0);
        stb_dly = 3;

        // Empty mask (R11)
        run_and_wait(16'h0000);
        chk("R11", "empty mask never busy", int'(saw_busy), 0);
        chk("R11", "empty mask done", int'(done), 1);
        chk("R12", "empty mask clears error", int'(error), 0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        report();
    end

endmodule